// File: doc/BRIEF.md
# Truncated Wide Multiplier

This unit is a multi-cycle multiplier for a 256-bit operand X and a 195-bit operand Y. It returns one 64-bit slice of the product X·Y and never stores the full 451-bit result. In high mode it returns bits 256 to 319 of the product, which is floor(X·Y / 2^256) mod 2^64. In low mode it returns bits 0 to 63, which is X·Y mod 2^64. A scalar-decomposition sequencer is expected to issue one request at a time and wait for the completion pulse.

Y is consumed in 17-bit digits and X is held as 24-bit words. A row stage multiplies one Y digit by X through a chain of 17×24 multiply-add cells, one cell per cycle. An adder-shifter then folds the row into a running sum that drops 17 bits off the bottom after every row. The adder-shifter works in three pipelined slices. Low mode uses the same hardware with fewer rows and fewer cells, and it collects the bits dropped off the bottom to form the result.

Top module: `wide_trunc_mul`

## Requirements
- R1: While reset is asserted and after it is released, done_o is 0 and zh_o and zl_o are both 0.
- R2: A start_i pulse with hi_sel_i=1 computes zh_o = floor(x_i·y_i / 2^256) mod 2^64, exact for any x_i < 2^256 and y_i < 2^195.
- R3: A start_i pulse with hi_sel_i=0 computes zl_o = x_i·y_i mod 2^64, exact for any operand values.
- R4: done_o rises 169 clock edges after the edge that samples start_i in high mode (12 rows of 11 cell cycles plus 3 add cycles, and one finishing cycle). In low mode it rises 25 edges after that edge (4 rows of 3 cell cycles plus 3 add cycles, and one finishing cycle).
- R5: done_o is high for exactly one cycle per accepted request.
- R6: A high-mode request leaves zl_o unchanged, and a low-mode request leaves zh_o unchanged.
- R7: A start_i pulse that arrives while a request is in progress is ignored: the running result, its mode and its timing are those of the request that was accepted.
- R8: zh_o and zl_o change only in the cycle in which done_o is high, and they hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled only when idle |
| hi_sel_i | input | 1 | 1 selects the high 64-bit slice, 0 selects the low 64-bit slice |
| x_i | input | 256 | Multiplicand X |
| y_i | input | 195 | Multiplier Y |
| zh_o | output | 64 | High-slice result |
| zl_o | output | 64 | Low-slice result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a carry that ripples across all three adder slices while the running sum sits near its widest value. Only operands with long runs of ones in both X and Y push the row results and the shifted sum high enough for that carry to cross the slice boundaries. The stimulus therefore uses all-ones operands and single-bit operands at the top of each range in both modes, along with random operands. A start pulse is injected in the middle of a long high-mode run with different operands and the opposite mode, so an accepted restart would show up in the result, in the untouched output or in the pulse timing.

// File: rtl/tmul_pkg.sv
package tmul_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_ROW, ST_ADD, ST_FIN} tmul_state_e;

   function automatic int cdiv(input int a, input int b);
      return (a + b - 1) / b;
   endfunction
endpackage

// File: rtl/tmul_cell.sv
module tmul_cell #(
   parameter int XD = 24,
   parameter int YD = 17
) (
   input  logic [YD-1:0]    dig_i,
   input  logic [XD-1:0]    word_i,
   input  logic [YD-1:0]    cin_i,
   output logic [XD+YD-1:0] p_o
);
   localparam int PW = XD + YD;
   // the carry fits the addend port: (2^YD-1)(2^XD-1) + 2^YD-1 < 2^PW
   assign p_o = PW'(dig_i) * PW'(word_i) + PW'(cin_i);
endmodule

// File: rtl/tmul_row.sv
module tmul_row #(
   parameter int XD = 24,
   parameter int YD = 17,
   parameter int NX = 11
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       en_i,
   input  logic [$clog2(NX)-1:0]      step_i,
   input  logic [$clog2(NX)-1:0]      last_i,
   input  logic [YD-1:0]              dig_i,
   input  logic [NX*XD-1:0]           x_i,
   output logic [NX*XD+YD-1:0]        t_o
);
   localparam int PW = XD + YD;
   localparam int SW = $clog2(NX);
   localparam int TW = NX * XD + YD;

   logic [PW-1:0] p_arr [NX];
   logic [XD-1:0] words_q [NX];
   logic [PW-1:0] top_q;
   logic [YD-1:0] carry_q;
   logic [YD-1:0] cin;
   logic [PW-1:0] p_sel;

   assign cin = (step_i == '0) ? '0 : carry_q;

   for (genvar g = 0; g < NX; g++) begin : g_cell
      tmul_cell #(.XD(XD), .YD(YD)) u_cell (
         .dig_i (dig_i),
         .word_i(x_i[g*XD +: XD]),
         .cin_i (cin),
         .p_o   (p_arr[g])
      );
   end

   assign p_sel = p_arr[step_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_q <= '0;
         top_q   <= '0;
         for (int j = 0; j < NX; j++) words_q[j] <= '0;
      end else if (en_i) begin
         carry_q <= p_sel[PW-1:XD];
         if (step_i == last_i) top_q <= p_sel;
         else                  words_q[step_i] <= p_sel[XD-1:0];
      end
   end

   always_comb begin
      t_o = '0;
      for (int j = 0; j < NX; j++)
         if (j < int'(last_i)) t_o[j*XD +: XD] = words_q[j];
      t_o[int'(last_i)*XD +: PW] = top_q;
   end

   // R2
   step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |-> (step_i <= last_i) && (int'(last_i) < NX));
endmodule

// File: rtl/tmul_addshift.sv
module tmul_addshift #(
   parameter int TW   = 281,
   parameter int YD   = 17,
   parameter int NSTG = 3
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   clr_i,
   input  logic                                   add_en_i,
   input  logic [$clog2(NSTG)-1:0]                stage_i,
   input  logic [TW-1:0]                          t_i,
   output logic [((TW+NSTG)/NSTG)*NSTG-1:0]       acc_o,
   output logic [YD-1:0]                          nxt_low_o
);
   localparam int CW    = (TW + NSTG) / NSTG;
   localparam int ACC_W = CW * NSTG;
   localparam int STW   = $clog2(NSTG);

   logic [ACC_W-1:0] acc_q, sum_q, sh, t_ext, nxt;
   logic             cy_q, cin;
   logic [CW:0]      s;
   int               base;

   assign sh    = acc_q >> YD;
   assign t_ext = ACC_W'(t_i);
   assign base  = int'(stage_i) * CW;
   assign cin   = (stage_i == '0) ? 1'b0 : cy_q;
   assign s     = {1'b0, sh[base +: CW]} + {1'b0, t_ext[base +: CW]} + (CW+1)'(cin);

   always_comb begin
      nxt = sum_q;
      nxt[base +: CW] = s[CW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         sum_q <= '0;
         cy_q  <= 1'b0;
      end else if (clr_i) begin
         acc_q <= '0;
         cy_q  <= 1'b0;
      end else if (add_en_i) begin
         sum_q <= nxt;
         cy_q  <= s[CW];
         if (stage_i == STW'(NSTG-1)) acc_q <= nxt;
      end
   end

   assign acc_o     = acc_q;
   assign nxt_low_o = nxt[YD-1:0];

   // R2
   no_carry_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (add_en_i && stage_i == STW'(NSTG-1)) |-> !s[CW]);
   // R2
   acc_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(acc_q) |-> $past(clr_i || (add_en_i && stage_i == STW'(NSTG-1))));
endmodule

// File: rtl/wide_trunc_mul.sv
module wide_trunc_mul
   import tmul_pkg::*;
#(
   parameter int XW    = 256,
   parameter int YW    = 195,
   parameter int XD    = 24,
   parameter int YD    = 17,
   parameter int OUT_W = 64,
   parameter int NSTG  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             hi_sel_i,
   input  logic [XW-1:0]    x_i,
   input  logic [YW-1:0]    y_i,
   output logic [OUT_W-1:0] zh_o,
   output logic [OUT_W-1:0] zl_o,
   output logic             done_o
);
   localparam int NX       = cdiv(XW, XD);
   localparam int NY       = cdiv(YW, YD);
   localparam int XPW      = NX * XD;
   localparam int YPW      = NY * YD;
   localparam int TW       = XPW + YD;
   localparam int ACC_W    = ((TW + NSTG) / NSTG) * NSTG;
   localparam int HI_SHIFT = XW - YD * (NY - 1);
   localparam int LO_ROWS  = cdiv(OUT_W, YD);
   localparam int LO_CELLS = cdiv(OUT_W, XD);
   localparam int ZL_W     = LO_ROWS * YD;
   localparam int SW       = $clog2(NX);
   localparam int RW       = $clog2(NY);
   localparam int STW      = $clog2(NSTG);
   localparam int LAT_HI   = 1 + NY * (NX + NSTG);
   localparam int LAT_LO   = 1 + LO_ROWS * (LO_CELLS + NSTG);

   if (HI_SHIFT < 0 || HI_SHIFT + OUT_W > ACC_W) begin : g_bad_shift
      $error("truncation point outside the accumulator");
   end
   if (LO_CELLS > NX || LO_ROWS > NY) begin : g_bad_low
      $error("low-mode bounds exceed the operand words");
   end
   if (NSTG < 2) begin : g_bad_stg
      $error("adder needs at least two slices");
   end

   tmul_state_e        state_q;
   logic [XPW-1:0]     x_q;
   logic [YPW-1:0]     y_q;
   logic               hi_q;
   logic [RW-1:0]      row_q, last_row;
   logic [SW-1:0]      step_q, last_cell;
   logic [STW-1:0]     stage_q;
   logic [ZL_W-1:0]    zl_acc;
   logic [TW-1:0]      row_t;
   logic [ACC_W-1:0]   acc;
   logic [YD-1:0]      nxt_low;
   logic [YD-1:0]      dig;
   logic               accept;
   logic [15:0]        lat_q;

   assign accept    = (state_q == ST_IDLE) && start_i;
   assign last_cell = hi_q ? SW'(NX - 1) : SW'(LO_CELLS - 1);
   assign last_row  = hi_q ? RW'(NY - 1) : RW'(LO_ROWS - 1);
   assign dig       = y_q[int'(row_q)*YD +: YD];

   tmul_row #(.XD(XD), .YD(YD), .NX(NX)) u_row (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (state_q == ST_ROW),
      .step_i(step_q),
      .last_i(last_cell),
      .dig_i (dig),
      .x_i   (x_q),
      .t_o   (row_t)
   );

   tmul_addshift #(.TW(TW), .YD(YD), .NSTG(NSTG)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (accept),
      .add_en_i (state_q == ST_ADD),
      .stage_i  (stage_q),
      .t_i      (row_t),
      .acc_o    (acc),
      .nxt_low_o(nxt_low)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         x_q     <= '0;
         y_q     <= '0;
         hi_q    <= 1'b0;
         row_q   <= '0;
         step_q  <= '0;
         stage_q <= '0;
         zl_acc  <= '0;
         zh_o    <= '0;
         zl_o    <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               x_q     <= XPW'(x_i);
               y_q     <= YPW'(y_i);
               hi_q    <= hi_sel_i;
               row_q   <= '0;
               step_q  <= '0;
               zl_acc  <= '0;
               state_q <= ST_ROW;
            end
            ST_ROW: begin
               if (step_q == last_cell) begin
                  stage_q <= '0;
                  state_q <= ST_ADD;
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
            ST_ADD: begin
               if (stage_q == STW'(NSTG - 1)) begin
                  stage_q <= '0;
                  if (int'(row_q) < LO_ROWS) zl_acc <= {nxt_low, zl_acc[ZL_W-1:YD]};
                  if (row_q == last_row) begin
                     state_q <= ST_FIN;
                  end else begin
                     row_q   <= row_q + 1'b1;
                     step_q  <= '0;
                     state_q <= ST_ROW;
                  end
               end else begin
                  stage_q <= stage_q + 1'b1;
               end
            end
            ST_FIN: begin
               if (hi_q) zh_o <= acc[HI_SHIFT +: OUT_W];
               else      zl_o <= zl_acc[OUT_W-1:0];
               done_o  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // latency counter for the checks below
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 lat_q <= '0;
      else if (accept)            lat_q <= '0;
      else if (state_q != ST_IDLE) lat_q <= lat_q + 1'b1;
   end

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R4
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> lat_q == (hi_q ? 16'(LAT_HI) : 16'(LAT_LO)));
   // R8
   zh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(zh_o) |-> done_o);
   // R8
   zl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(zl_o) |-> done_o);
   // R6
   other_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (hi_q ? $stable(zl_o) : $stable(zh_o)));
   // R3
   low_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hi_q && state_q != ST_IDLE) |-> int'(row_q) < LO_ROWS);
endmodule

// File: tb/sim_wide_trunc_mul.sv
module sim_wide_trunc_mul;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         hi_sel = 1'b0;
   logic [255:0] x = '0;
   logic [194:0] y = '0;
   logic [63:0]  zh, zl;
   logic         done;

   int    n_tests = 0;
   int    n_fail  = 0;
   int    cyc     = 0;
   string cur_req = "R1";

   // reference model state
   bit          m_busy = 0;
   bit          m_done = 0;
   int          m_cnt  = 0;
   bit          m_hi   = 0;
   logic [450:0] m_x = '0, m_y = '0, m_prod = '0;
   logic [63:0] m_zh = '0, m_zl = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wide_trunc_mul u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .hi_sel_i(hi_sel),
      .x_i(x), .y_i(y), .zh_o(zh), .zl_o(zl), .done_o(done)
   );

   // R4: 169 edges (high) or 25 edges (low) from the sampling edge to done
   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_zh = '0; m_zl = '0;
      end else begin
         m_done = 0;
         if (!m_busy && start) begin
            m_busy = 1;
            m_hi   = hi_sel;
            m_cnt  = hi_sel ? 169 : 25;
            m_x    = 451'(x);
            m_y    = 451'(y);
         end else if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_busy = 0;
               m_done = 1;
               m_prod = m_x * m_y;
               if (m_hi) m_zh = m_prod[319:256];
               else      m_zl = m_prod[63:0];
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         n_tests++;
         if (done !== m_done) begin
            n_fail++;
            $display("FAIL R4 R5 done: actual=%0b expected=%0b", done, m_done);
         end
         n_tests++;
         if (zh !== m_zh) begin
            n_fail++;
            $display("FAIL %s zh: actual=%h expected=%h", m_done ? cur_req : "R8", zh, m_zh);
         end
         n_tests++;
         if (zl !== m_zl) begin
            n_fail++;
            $display("FAIL %s zl: actual=%h expected=%h", m_done ? cur_req : "R8", zl, m_zl);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         n_fail++;
         $display("FAIL R4 watchdog: actual=%0d cycles expected=below %0d", cyc, WATCHDOG);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic run(input logic [255:0] a, input logic [194:0] b, input bit hi, input string req);
      cur_req = req;
      @(negedge clk);
      x = a; y = b; hi_sel = hi; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (m_busy) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [255:0] rnd256();
      logic [255:0] v;
      for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
      return v;
   endfunction

   initial begin
      // R1: reset values
      repeat (3) @(negedge clk);
      n_tests++;
      if (done !== 1'b0 || zh !== '0 || zl !== '0) begin
         n_fail++;
         $display("FAIL R1 reset: actual=%0b/%h/%h expected=0/0/0", done, zh, zl);
      end
      rst_n = 1'b1;
      @(negedge clk);

      run('0, '1, 1'b1, "R2 R6");
      run('0, '1, 1'b0, "R3 R6");
      run('1, '1, 1'b1, "R2 R6");
      run('1, '1, 1'b0, "R3 R6");
      run(256'd1, 195'd1, 1'b0, "R3");
      run(256'd1, 195'd1, 1'b1, "R2");
      run('1, 195'd1 << 194, 1'b1, "R2");
      run(256'd1 << 255, '1, 1'b1, "R2");
      run(256'hFFFF_FFFF_FFFF_FFFF, 195'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R3");

      // R7: a second start during a high-mode run is ignored
      cur_req = "R7";
      @(negedge clk);
      x = rnd256(); y = 195'(rnd256()); hi_sel = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      x = '1; y = '1; hi_sel = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (m_busy) @(negedge clk);
      @(negedge clk);

      for (int k = 0; k < 8; k++) run(rnd256(), 195'(rnd256()), 1'b1, "R2 R6");
      for (int k = 0; k < 8; k++) run(rnd256(), 195'(rnd256()), 1'b0, "R3 R6");
      repeat (5) @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule